// File: doc/BRIEF.md
# Two-Way-Protected Random Replacement Selector

This block keeps the replacement and cleanliness metadata of an 8-way set-associative write-back cache with 64-byte lines. Each set has a valid bit per way, an 8-bit dirty mask per way with one bit for each 8-byte word, and two pointers that name the two ways used most recently. The lookup logic reports hits, write hits and refills. The block updates the pointers and the masks in response.

On a miss request for a set, the block picks the way to replace. An empty way is always taken first. When the set is full, the choice is pseudo-random, and the two most recently used ways are excluded from it. One cycle after the request, the block reports the chosen way and that way's dirty-word mask, so only the modified words need to be written back. Tag compare, data storage and the memory bus are outside this block.

Top module: `pmru_victim_sel`

## Requirements
- R1: After the active-low reset, every way of every set is invalid with a clear dirty mask, MRU0 is way 0, MRU1 is way 1, the LFSR holds 16'hACE1 and victim_valid_o is low.
- R2: A miss request in cycle N makes victim_valid_o high in cycle N+1 only. The reported way and mask reflect the set state before the edge that ends cycle N.
- R3: If the requested set has an invalid way, the victim is the lowest-numbered invalid way and its reported mask is all zero.
- R4: If all ways of the set are valid, the victim is never MRU0 or MRU1 of that set.
- R5: In a full set, the candidate is bits [2:0] of a 16-bit Fibonacci LFSR. The LFSR is seeded 16'hACE1, shifts left every clock out of reset, and takes as its new bit 0 the XOR of bits 15, 13, 12 and 10. If the candidate is protected, the first unprotected way found by counting upward modulo 8 is used.
- R6: An access to way w with w not equal to MRU0 moves the old MRU0 into MRU1 and sets MRU0 to w. An access to MRU0 changes neither pointer.
- R7: A write access sets dirty bit k of the addressed way, where bit k covers bytes 8k to 8k+7 of the line. A read access changes no dirty bit. A write to an invalid way leaves its mask clear.
- R8: A refill marks the way valid, clears its whole dirty mask and updates the pointers as in R6.
- R9: victim_dirty_o is the dirty mask of the chosen way, with bit k for word k.
- R10: When a refill and an access are presented in the same cycle, the refill is applied and the access is ignored.
- R11: Operations on one set leave the state of every other set unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_valid_i | input | 1 | Hit access strobe |
| acc_set_i | input | SET_W (8) | Set of the access |
| acc_way_i | input | WAY_W (3) | Way that hit |
| acc_write_i | input | 1 | Access is a write |
| acc_word_i | input | WORD_W (3) | Word index written |
| fill_valid_i | input | 1 | Refill strobe |
| fill_set_i | input | SET_W (8) | Set being refilled |
| fill_way_i | input | WAY_W (3) | Way being refilled |
| miss_valid_i | input | 1 | Victim request strobe |
| miss_set_i | input | SET_W (8) | Set needing a victim |
| victim_valid_o | output | 1 | Victim report valid |
| victim_way_o | output | WAY_W (3) | Chosen way |
| victim_dirty_o | output | WORDS_PER_BLOCK (8) | Dirty-word mask of the chosen way |

## Verification
The bench builds the block with 4 sets, 8 ways and 8 words per line. The small set count makes it quick to fill a set completely, to run many random choices against the protected pair, and to show that untouched sets stay empty. The bench keeps its own model of the LFSR, the pointers and the masks, so every random victim has one exact expected way. Line sizes and way counts are kept at their defaults, so the protected-skip rule is tested with the same modulo-8 wrap as the full-size block.

// File: rtl/pmru_pkg.sv
package pmru_pkg;
  localparam int unsigned LFSR_W = 16;

  // taps 16,14,13,11 in polynomial terms
  function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
    return {s[LFSR_W-2:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction
endpackage

// File: rtl/pmru_lfsr.sv
module pmru_lfsr
  import pmru_pkg::*;
#(
  parameter logic [LFSR_W-1:0] SEED = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEED;
    else         state_q <= lfsr_step(state_q);
  end

  assign state_o = state_q;
endmodule

// File: rtl/pmru_set_meta.sv
module pmru_set_meta #(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned WORDS    = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS),
  localparam int unsigned WORD_W  = $clog2(WORDS)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      fill_i,
  input  logic                      acc_i,
  input  logic [WAY_W-1:0]          way_i,
  input  logic                      wr_i,
  input  logic [WORD_W-1:0]         word_i,
  output logic [NUM_WAYS-1:0]       valid_o,
  output logic [NUM_WAYS*WORDS-1:0] dirty_o,
  output logic [WAY_W-1:0]          mru0_o,
  output logic [WAY_W-1:0]          mru1_o
);
  logic [NUM_WAYS-1:0]            valid_q;
  logic [NUM_WAYS-1:0][WORDS-1:0] dirty_q;
  logic [WAY_W-1:0]               mru0_q, mru1_q;
  logic                           touch;

  assign touch = fill_i || acc_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      dirty_q <= '0;
      mru0_q  <= '0;
      mru1_q  <= WAY_W'(1);
    end else begin
      if (fill_i) begin
        valid_q[way_i] <= 1'b1;
        dirty_q[way_i] <= '0;
      end else if (acc_i && wr_i && valid_q[way_i]) begin
        dirty_q[way_i][word_i] <= 1'b1;
      end
      if (touch && (way_i != mru0_q)) begin
        mru1_q <= mru0_q;
        mru0_q <= way_i;
      end
    end
  end

  assign valid_o = valid_q;
  assign dirty_o = dirty_q;
  assign mru0_o  = mru0_q;
  assign mru1_o  = mru1_q;
endmodule

// File: rtl/pmru_pick.sv
module pmru_pick #(
  parameter int unsigned NUM_WAYS = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic [NUM_WAYS-1:0] valid_i,
  input  logic [WAY_W-1:0]    mru0_i,
  input  logic [WAY_W-1:0]    mru1_i,
  input  logic [WAY_W-1:0]    rnd_i,
  output logic [WAY_W-1:0]    way_o,
  output logic                full_o
);
  logic [NUM_WAYS-1:0] prot;
  logic [WAY_W-1:0]    inv_way, skip_way, idx;

  always_comb begin
    full_o  = &valid_i;
    inv_way = '0;
    // descending scan leaves the lowest invalid way
    for (int i = NUM_WAYS - 1; i >= 0; i--) begin
      if (!valid_i[i]) inv_way = WAY_W'(i);
    end

    prot         = '0;
    prot[mru0_i] = 1'b1;
    prot[mru1_i] = 1'b1;
    skip_way     = rnd_i;
    idx          = rnd_i;
    // descending offsets leave the nearest unprotected way above rnd_i
    for (int k = NUM_WAYS - 1; k >= 1; k--) begin
      idx = rnd_i + WAY_W'(k);
      if (!prot[idx]) skip_way = idx;
    end

    if (!full_o)          way_o = inv_way;
    else if (prot[rnd_i]) way_o = skip_way;
    else                  way_o = rnd_i;
  end
endmodule

// File: rtl/pmru_victim_sel.sv
module pmru_victim_sel
  import pmru_pkg::*;
#(
  parameter int unsigned       NUM_SETS        = 256,
  parameter int unsigned       NUM_WAYS        = 8,
  parameter int unsigned       WORDS_PER_BLOCK = 8,
  parameter logic [LFSR_W-1:0] LFSR_SEED       = 16'hACE1,
  localparam int unsigned      SET_W           = $clog2(NUM_SETS),
  localparam int unsigned      WAY_W           = $clog2(NUM_WAYS),
  localparam int unsigned      WORD_W          = $clog2(WORDS_PER_BLOCK)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       acc_valid_i,
  input  logic [SET_W-1:0]           acc_set_i,
  input  logic [WAY_W-1:0]           acc_way_i,
  input  logic                       acc_write_i,
  input  logic [WORD_W-1:0]          acc_word_i,
  input  logic                       fill_valid_i,
  input  logic [SET_W-1:0]           fill_set_i,
  input  logic [WAY_W-1:0]           fill_way_i,
  input  logic                       miss_valid_i,
  input  logic [SET_W-1:0]           miss_set_i,
  output logic                       victim_valid_o,
  output logic [WAY_W-1:0]           victim_way_o,
  output logic [WORDS_PER_BLOCK-1:0] victim_dirty_o
);
  localparam int unsigned LINE_BITS = NUM_WAYS * WORDS_PER_BLOCK;

  logic [NUM_WAYS-1:0]  set_valid [NUM_SETS];
  logic [LINE_BITS-1:0] set_dirty [NUM_SETS];
  logic [WAY_W-1:0]     set_mru0  [NUM_SETS];
  logic [WAY_W-1:0]     set_mru1  [NUM_SETS];

  logic [LFSR_W-1:0]    lfsr;
  logic [WAY_W-1:0]     upd_way, pick_way;
  logic                 pick_full;
  logic [LINE_BITS-1:0] miss_dirty;

  // refill has priority; a colliding access is dropped
  assign upd_way = fill_valid_i ? fill_way_i : acc_way_i;

  pmru_lfsr #(.SEED(LFSR_SEED)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .state_o (lfsr)
  );

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic sel_fill, sel_acc;
    assign sel_fill = fill_valid_i && (fill_set_i == SET_W'(s));
    assign sel_acc  = acc_valid_i && !fill_valid_i && (acc_set_i == SET_W'(s));

    pmru_set_meta #(.NUM_WAYS(NUM_WAYS), .WORDS(WORDS_PER_BLOCK)) i_meta (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fill_i  (sel_fill),
      .acc_i   (sel_acc),
      .way_i   (upd_way),
      .wr_i    (acc_write_i),
      .word_i  (acc_word_i),
      .valid_o (set_valid[s]),
      .dirty_o (set_dirty[s]),
      .mru0_o  (set_mru0[s]),
      .mru1_o  (set_mru1[s])
    );
  end

  pmru_pick #(.NUM_WAYS(NUM_WAYS)) i_pick (
    .valid_i (set_valid[miss_set_i]),
    .mru0_i  (set_mru0[miss_set_i]),
    .mru1_i  (set_mru1[miss_set_i]),
    .rnd_i   (lfsr[WAY_W-1:0]),
    .way_o   (pick_way),
    .full_o  (pick_full)
  );

  assign miss_dirty = set_dirty[miss_set_i];

  logic                       vic_valid_q, vic_full_q;
  logic [WAY_W-1:0]           vic_way_q, vic_prot0_q, vic_prot1_q;
  logic [WORDS_PER_BLOCK-1:0] vic_dirty_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vic_valid_q <= 1'b0;
      vic_full_q  <= 1'b0;
      vic_way_q   <= '0;
      vic_prot0_q <= '0;
      vic_prot1_q <= '0;
      vic_dirty_q <= '0;
    end else begin
      vic_valid_q <= miss_valid_i;
      if (miss_valid_i) begin
        vic_way_q   <= pick_way;
        vic_full_q  <= pick_full;
        vic_prot0_q <= set_mru0[miss_set_i];
        vic_prot1_q <= set_mru1[miss_set_i];
        vic_dirty_q <= miss_dirty[pick_way*WORDS_PER_BLOCK +: WORDS_PER_BLOCK];
      end
    end
  end

  assign victim_valid_o = vic_valid_q;
  assign victim_way_o   = vic_way_q;
  assign victim_dirty_o = vic_dirty_q;
endmodule

// File: rtl/pmru_chk.sv
module pmru_chk #(
  parameter int unsigned NUM_WAYS = 8,
  parameter int unsigned WORDS    = 8,
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             miss_valid_i,
  input logic             victim_valid_o,
  input logic [WAY_W-1:0] victim_way_o,
  input logic [WORDS-1:0] victim_dirty_o,
  input logic             vic_full_q,
  input logic [WAY_W-1:0] vic_prot0_q,
  input logic [WAY_W-1:0] vic_prot1_q,
  input logic [WAY_W-1:0] acc_mru0,
  input logic [WAY_W-1:0] acc_mru1
);
  AST_VIC_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_valid_i |=> victim_valid_o); // R2

  AST_VIC_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !miss_valid_i |=> !victim_valid_o); // R2

  AST_VIC_UNPROTECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (victim_valid_o && vic_full_q) |->
      (victim_way_o != vic_prot0_q) && (victim_way_o != vic_prot1_q)); // R4

  AST_EMPTY_WAY_CLEAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (victim_valid_o && !vic_full_q) |-> (victim_dirty_o == '0)); // R3

  AST_MRU_DISTINCT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_mru0 != acc_mru1); // R6
endmodule

bind pmru_victim_sel pmru_chk #(.NUM_WAYS(NUM_WAYS), .WORDS(WORDS_PER_BLOCK)) i_pmru_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .miss_valid_i   (miss_valid_i),
  .victim_valid_o (victim_valid_o),
  .victim_way_o   (victim_way_o),
  .victim_dirty_o (victim_dirty_o),
  .vic_full_q     (vic_full_q),
  .vic_prot0_q    (vic_prot0_q),
  .vic_prot1_q    (vic_prot1_q),
  .acc_mru0       (set_mru0[acc_set_i]),
  .acc_mru1       (set_mru1[acc_set_i])
);

// File: tb/test_pmru_victim_sel.sv
module test_pmru_victim_sel;
  localparam int NS = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       acc_valid = 1'b0, acc_write = 1'b0, fill_valid = 1'b0, miss_valid = 1'b0;
  logic [1:0] acc_set = '0, fill_set = '0, miss_set = '0;
  logic [2:0] acc_way = '0, acc_word = '0, fill_way = '0;
  logic       victim_valid;
  logic [2:0] victim_way;
  logic [7:0] victim_dirty;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk; // 125 MHz

  pmru_victim_sel #(.NUM_SETS(NS)) i_pmru_victim_sel (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .acc_valid_i    (acc_valid),
    .acc_set_i      (acc_set),
    .acc_way_i      (acc_way),
    .acc_write_i    (acc_write),
    .acc_word_i     (acc_word),
    .fill_valid_i   (fill_valid),
    .fill_set_i     (fill_set),
    .fill_way_i     (fill_way),
    .miss_valid_i   (miss_valid),
    .miss_set_i     (miss_set),
    .victim_valid_o (victim_valid),
    .victim_way_o   (victim_way),
    .victim_dirty_o (victim_dirty)
  );

  // reference model built from R1, R5..R8
  logic [15:0] m_lfsr;
  logic [7:0]  mv  [NS];
  logic [7:0]  md  [NS][8];
  logic [2:0]  mm0 [NS];
  logic [2:0]  mm1 [NS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) m_lfsr <= 16'hACE1;
    else        m_lfsr <= {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
  end

  task automatic m_reset();
    for (int s = 0; s < NS; s++) begin
      mv[s] = '0; mm0[s] = 3'd0; mm1[s] = 3'd1;
      for (int w = 0; w < 8; w++) md[s][w] = '0;
    end
  endtask

  task automatic m_touch(input int s, input logic [2:0] w);
    if (w != mm0[s]) begin mm1[s] = mm0[s]; mm0[s] = w; end
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    acc_valid = 0; fill_valid = 0; miss_valid = 0; acc_write = 0;
  endtask

  task automatic do_fill(input int s, input int w);
    @(negedge clk); idle_inputs();
    fill_valid = 1; fill_set = 2'(s); fill_way = 3'(w);
    mv[s][w] = 1'b1; md[s][w] = '0; m_touch(s, 3'(w)); // R8
  endtask

  task automatic do_acc(input int s, input int w, input logic wr, input int wd);
    @(negedge clk); idle_inputs();
    acc_valid = 1; acc_set = 2'(s); acc_way = 3'(w); acc_write = wr; acc_word = 3'(wd);
    if (wr && mv[s][w]) md[s][w][wd] = 1'b1; // R7
    m_touch(s, 3'(w)); // R6
  endtask

  task automatic do_idle();
    @(negedge clk); idle_inputs();
  endtask

  task automatic do_miss(input int s, input string tag);
    logic [2:0] ew;
    logic       full;
    @(negedge clk); idle_inputs();
    miss_valid = 1; miss_set = 2'(s);
    full = &mv[s];
    ew = 3'd0;
    if (!full) begin
      for (int i = 7; i >= 0; i--) if (!mv[s][i]) ew = 3'(i);
    end else begin
      for (int k = 7; k >= 0; k--) begin
        logic [2:0] c;
        c = m_lfsr[2:0] + 3'(k);
        if (c != mm0[s] && c != mm1[s]) ew = c;
      end
    end
    @(posedge clk); #1;
    check({"R2 ", tag}, 32'(victim_valid), 32'd1);
    check(full ? {"R4/R5 ", tag} : {"R3 ", tag}, 32'(victim_way), 32'(ew));
    check({"R9 ", tag}, 32'(victim_dirty), 32'(md[s][ew]));
  endtask

  // vector: {op[1:0], set[1:0], way[2:0], wr, word[2:0]}; op 0 fill, 1 access, 2 miss, 3 idle
  localparam int NV = 40;
  localparam logic [10:0] VEC [NV] = '{
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},  // R3 empty set
    {2'd0, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},  // R3 next invalid
    {2'd0, 2'd0, 3'd1, 1'b0, 3'd0},
    {2'd0, 2'd0, 3'd2, 1'b0, 3'd0},
    {2'd0, 2'd0, 3'd3, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd0, 2'd0, 3'd4, 1'b0, 3'd0},
    {2'd0, 2'd0, 3'd5, 1'b0, 3'd0},
    {2'd0, 2'd0, 3'd6, 1'b0, 3'd0},
    {2'd0, 2'd0, 3'd7, 1'b0, 3'd0},
    {2'd1, 2'd0, 3'd2, 1'b1, 3'd5},  // R7 write word 5
    {2'd1, 2'd0, 3'd2, 1'b1, 3'd0},
    {2'd1, 2'd0, 3'd3, 1'b1, 3'd7},
    {2'd1, 2'd0, 3'd4, 1'b1, 3'd1},
    {2'd1, 2'd0, 3'd0, 1'b1, 3'd2},
    {2'd1, 2'd0, 3'd6, 1'b0, 3'd0},  // R6 read access, MRU0=6 MRU1=0
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},  // R4 full set
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd1, 2'd0, 3'd5, 1'b1, 3'd7},
    {2'd1, 2'd0, 3'd5, 1'b1, 3'd6},  // R6 repeat of MRU0
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd3, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd1, 2'd0, 3'd2, 1'b0, 3'd0},
    {2'd1, 2'd0, 3'd3, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd0, 2'd1, 3'd3, 1'b0, 3'd0},  // R11 other set
    {2'd2, 2'd1, 3'd0, 1'b0, 3'd0},
    {2'd1, 2'd1, 3'd3, 1'b1, 3'd4},
    {2'd2, 2'd1, 3'd0, 1'b0, 3'd0},
    {2'd0, 2'd0, 3'd2, 1'b0, 3'd0},  // R8 refill clears mask
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd1, 2'd0, 3'd7, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0},
    {2'd2, 2'd0, 3'd0, 1'b0, 3'd0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R2 watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    m_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 check("R1 victim_valid after reset", 32'(victim_valid), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] op;
      int s, w, wd;
      logic wr;
      op = VEC[i][10:9]; s = int'(VEC[i][8:7]); w = int'(VEC[i][6:4]);
      wr = VEC[i][3]; wd = int'(VEC[i][2:0]);
      case (op)
        2'd0:    do_fill(s, w);
        2'd1:    do_acc(s, w, wr, wd);
        2'd2:    do_miss(s, $sformatf("vec %0d", i));
        default: do_idle();
      endcase
    end

    // R2: pulse drops without a request
    do_idle();
    @(posedge clk); #1;
    check("R2 no request", 32'(victim_valid), 32'd0);

    // R11: set 2 never touched
    do_miss(2, "R11 untouched set");

    // R10: refill and access collide; access must be dropped
    for (int w = 0; w < 8; w++) do_fill(3, w);
    do_acc(3, 1, 1'b1, 6);
    @(negedge clk); idle_inputs();
    fill_valid = 1; fill_set = 2'd3; fill_way = 3'd1;
    acc_valid = 1; acc_set = 2'd3; acc_way = 3'd4; acc_write = 1; acc_word = 3'd3;
    mv[3][1] = 1'b1; md[3][1] = '0; m_touch(3, 3'd1);
    for (int k = 0; k < 12; k++) do_miss(3, "R10 collision");

    // R1: reset mid-run returns every set to empty
    @(negedge clk); idle_inputs(); rst_n = 0;
    m_reset();
    #1 check("R1 victim_valid in reset", 32'(victim_valid), 32'd0);
    @(negedge clk); rst_n = 1;
    do_miss(0, "R1 after second reset");
    do_idle();

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule